// File: doc/BRIEF.md
# Control Endpoint Setup Lockout

This block sits beside the control endpoint pair of a USB device controller. It watches Setup packets as they land in the control buffer. It decides whether the microprocessor's buffer commands for control IN and control OUT may take effect. When a Setup packet arrives, the block closes a lockout. Commands that validate or clear a control buffer are then refused until firmware sends the acknowledge-setup command. A refused command produces a one-cycle rejection pulse instead of an operation pulse.

The block also keeps a small status image for firmware to read:
- A sticky overwrite flag records that a newer Setup replaced setup data that had not yet been acknowledged or stalled.
- A setup-present flag shows that the control buffer holds a Setup packet.
- A buffer-select bit shows which of two buffers the CPU may access.

Reading the image clears the overwrite flag, but only once the new setup data has been written completely. Firmware checks this flag before it acknowledges or stalls, and drops its setup handling when the flag is set.

Top module: `ctl_setup_lockout`

## Requirements
- R1: A synchronous active-high reset clears the overwrite and setup-present flags, selects the primary buffer (bit 0) and opens the lockout. After reset, no operation or rejection pulse is active.
- R2: A Setup arrival closes the lockout from the next cycle. A validate or clear command presented in the same cycle as the Setup is already refused.
- R3: The acknowledge command (code 0xF4, no data) opens the lockout. If a Setup arrives in the same cycle as the acknowledge, the lockout stays closed.
- R4: While the lockout is closed, a validate or clear command produces no operation pulse. Instead, the rejection output pulses high for exactly one cycle, one cycle after the command.
- R5: While the lockout is open, each accepted command raises its own output for exactly one cycle, one cycle after the command. The codes are 0xFA for validate OUT, 0xFB for validate IN, 0xF2 for clear OUT and 0xF3 for clear IN.
- R6: The overwrite flag sets when a Setup arrives while the previous Setup is still neither acknowledged nor stalled. A stall event or the acknowledge command closes that window.
- R7: A status read clears the overwrite flag only when the setup-write-done input is high. A read with that input low leaves the flag unchanged.
- R8: A status read in the same cycle as an overwrite-setting Setup leaves the flag set.
- R9: The setup-present flag sets on a Setup arrival and clears on an accepted clear-OUT command.
- R10: The CPU buffer bit is forced to primary (0) by a Setup arrival and toggles on each accepted clear-OUT command.
- R11: The status image carries overwrite at bit 3, setup-present at bit 2 and CPU buffer at bit 1. Bit 0 and all higher bits read 0.
- R12: A command strobe with any other code changes no output and no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| setup_rcvd | input | 1 | One-cycle strobe: a Setup packet arrived |
| setup_wr_done | input | 1 | Writing of the latest setup data has finished |
| stall_evt | input | 1 | One-cycle strobe: the control endpoint was stalled |
| cmd_code | input | CMD_W | Microprocessor command code |
| cmd_stb | input | 1 | Command strobe |
| stat_rd | input | 1 | Status image read strobe |
| stat_img | output | IMG_W | Status image |
| val_out_go | output | 1 | Accepted validate for control OUT |
| val_in_go | output | 1 | Accepted validate for control IN |
| clr_out_go | output | 1 | Accepted clear for control OUT |
| clr_in_go | output | 1 | Accepted clear for control IN |
| cmd_rej | output | 1 | A gated command was refused |

## Verification
A directed sequence comes first. It walks the lockout through accept, refuse, overwrite, read without write-done, read coinciding with a new Setup, and acknowledge. This separates the hold cases from the clear cases of each flag.

A long deterministic sweep follows. It mixes all six command code classes with Setup, stall, read and write-done in every combination and in many state contexts. In particular it covers simultaneous Setup with acknowledge, with stall and with gated commands, which tell apart the priority orders.

Each cycle the outputs and the image bits are compared against an arithmetic model of the requirements.

// File: rtl/ctl_lock_pkg.sv
package ctl_lock_pkg;

   typedef enum logic [2:0] {
      OP_NONE    = 3'd0,
      OP_ACK     = 3'd1,
      OP_VAL_OUT = 3'd2,
      OP_VAL_IN  = 3'd3,
      OP_CLR_OUT = 3'd4,
      OP_CLR_IN  = 3'd5
   } ctl_op_e;

   localparam int unsigned N_GATED = 4;

   // index of a gated op in the pulse vector
   function automatic int unsigned gated_idx(ctl_op_e op);
      case (op)
         OP_VAL_OUT: return 0;
         OP_VAL_IN:  return 1;
         OP_CLR_OUT: return 2;
         default:    return 3;
      endcase
   endfunction

   function automatic logic is_gated(ctl_op_e op);
      return (op == OP_VAL_OUT) || (op == OP_VAL_IN) ||
             (op == OP_CLR_OUT) || (op == OP_CLR_IN);
   endfunction

endpackage

// File: rtl/ctl_cmd_decode.sv
module ctl_cmd_decode
   import ctl_lock_pkg::*;
#(
   parameter int unsigned    CMD_W        = 8,
   parameter logic [CMD_W-1:0] CODE_ACK     = 8'hF4,
   parameter logic [CMD_W-1:0] CODE_VAL_OUT = 8'hFA,
   parameter logic [CMD_W-1:0] CODE_VAL_IN  = 8'hFB,
   parameter logic [CMD_W-1:0] CODE_CLR_OUT = 8'hF2,
   parameter logic [CMD_W-1:0] CODE_CLR_IN  = 8'hF3
)(
   input  logic [CMD_W-1:0] code,
   input  logic             stb,
   output ctl_op_e          op
);

   always_comb begin
      op = OP_NONE;
      if (stb) begin
         if (code == CODE_ACK)          op = OP_ACK;
         else if (code == CODE_VAL_OUT) op = OP_VAL_OUT;
         else if (code == CODE_VAL_IN)  op = OP_VAL_IN;
         else if (code == CODE_CLR_OUT) op = OP_CLR_OUT;
         else if (code == CODE_CLR_IN)  op = OP_CLR_IN;
      end
   end

endmodule

// File: rtl/ctl_setup_track.sv
module ctl_setup_track (
   input  logic clk,
   input  logic rst,
   input  logic setup_rcvd,
   input  logic stall_evt,
   input  logic ack,
   input  logic clr_out_acc,
   input  logic rd,
   input  logic wr_done,
   output logic locked,
   output logic ovw,
   output logic present
);

   logic window;

   always_ff @(posedge clk) begin
      if (rst) begin
         locked  <= 1'b0;
         window  <= 1'b0;
         ovw     <= 1'b0;
         present <= 1'b0;
      end else begin
         if (setup_rcvd)  locked <= 1'b1;
         else if (ack)    locked <= 1'b0;

         if (setup_rcvd)            window <= 1'b1;
         else if (ack || stall_evt) window <= 1'b0;

         if (setup_rcvd && window)  ovw <= 1'b1;
         else if (rd && wr_done)    ovw <= 1'b0;

         if (setup_rcvd)       present <= 1'b1;
         else if (clr_out_acc) present <= 1'b0;
      end
   end

   a_r2_lock_on_setup: assert property (@(posedge clk) disable iff (rst)
      setup_rcvd |=> locked);
   a_r3_ack_release: assert property (@(posedge clk) disable iff (rst)
      (ack && !setup_rcvd) |=> !locked);
   a_r6_ovw_set: assert property (@(posedge clk) disable iff (rst)
      (setup_rcvd && window) |=> ovw);
   a_r7_hold_until_done: assert property (@(posedge clk) disable iff (rst)
      (ovw && !wr_done) |=> ovw);
   a_r8_read_loses_to_set: assert property (@(posedge clk) disable iff (rst)
      (setup_rcvd && window && rd && wr_done) |=> ovw);
   a_r9_present_on_setup: assert property (@(posedge clk) disable iff (rst)
      setup_rcvd |=> present);

endmodule

// File: rtl/ctl_buf_sel.sv
module ctl_buf_sel #(
   parameter bit DOUBLE_BUF = 1'b1
)(
   input  logic clk,
   input  logic rst,
   input  logic setup_rcvd,
   input  logic clr_out_acc,
   output logic cpu_buf
);

   generate
      if (DOUBLE_BUF) begin : g_dual
         logic sel_q;
         always_ff @(posedge clk) begin
            if (rst)              sel_q <= 1'b0;
            else if (setup_rcvd)  sel_q <= 1'b0;
            else if (clr_out_acc) sel_q <= ~sel_q;
         end
         assign cpu_buf = sel_q;
      end else begin : g_single
         assign cpu_buf = 1'b0;
      end
   endgenerate

   a_r10_primary_after_setup: assert property (@(posedge clk) disable iff (rst)
      setup_rcvd |=> !cpu_buf);

endmodule

// File: rtl/ctl_setup_lockout.sv
module ctl_setup_lockout
   import ctl_lock_pkg::*;
#(
   parameter int unsigned      CMD_W        = 8,
   parameter int unsigned      IMG_W        = 8,
   parameter bit               DOUBLE_BUF   = 1'b1,
   parameter logic [CMD_W-1:0] CODE_ACK     = 8'hF4,
   parameter logic [CMD_W-1:0] CODE_VAL_OUT = 8'hFA,
   parameter logic [CMD_W-1:0] CODE_VAL_IN  = 8'hFB,
   parameter logic [CMD_W-1:0] CODE_CLR_OUT = 8'hF2,
   parameter logic [CMD_W-1:0] CODE_CLR_IN  = 8'hF3
)(
   input  logic             clk,
   input  logic             rst,
   input  logic             setup_rcvd,
   input  logic             setup_wr_done,
   input  logic             stall_evt,
   input  logic [CMD_W-1:0] cmd_code,
   input  logic             cmd_stb,
   input  logic             stat_rd,
   output logic [IMG_W-1:0] stat_img,
   output logic             val_out_go,
   output logic             val_in_go,
   output logic             clr_out_go,
   output logic             clr_in_go,
   output logic             cmd_rej
);

   localparam int unsigned BIT_OVW  = 3;
   localparam int unsigned BIT_PRES = 2;
   localparam int unsigned BIT_BUF  = 1;

   generate
      if (IMG_W < 4) begin : g_bad_img
         $error("IMG_W must hold bits 0..3");
      end
      if (CMD_W < 1) begin : g_bad_cmd
         $error("CMD_W must be positive");
      end
      if (CODE_ACK == CODE_VAL_OUT || CODE_ACK == CODE_VAL_IN ||
          CODE_ACK == CODE_CLR_OUT || CODE_ACK == CODE_CLR_IN ||
          CODE_VAL_OUT == CODE_VAL_IN || CODE_VAL_OUT == CODE_CLR_OUT ||
          CODE_VAL_OUT == CODE_CLR_IN || CODE_VAL_IN == CODE_CLR_OUT ||
          CODE_VAL_IN == CODE_CLR_IN || CODE_CLR_OUT == CODE_CLR_IN) begin : g_bad_codes
         $error("command codes must be distinct");
      end
   endgenerate

   ctl_op_e op;
   logic    locked, ovw, present, cpu_buf;
   logic    blocked, gated, ack, clr_out_acc;
   logic [N_GATED-1:0] go_q;
   logic    rej_q;

   ctl_cmd_decode #(
      .CMD_W(CMD_W), .CODE_ACK(CODE_ACK), .CODE_VAL_OUT(CODE_VAL_OUT),
      .CODE_VAL_IN(CODE_VAL_IN), .CODE_CLR_OUT(CODE_CLR_OUT),
      .CODE_CLR_IN(CODE_CLR_IN)
   ) i_dec (
      .code(cmd_code), .stb(cmd_stb), .op(op)
   );

   assign gated       = is_gated(op);
   assign blocked     = locked || setup_rcvd;
   assign ack         = (op == OP_ACK);
   assign clr_out_acc = (op == OP_CLR_OUT) && !blocked;

   ctl_setup_track i_trk (
      .clk(clk), .rst(rst), .setup_rcvd(setup_rcvd), .stall_evt(stall_evt),
      .ack(ack), .clr_out_acc(clr_out_acc), .rd(stat_rd),
      .wr_done(setup_wr_done), .locked(locked), .ovw(ovw), .present(present)
   );

   ctl_buf_sel #(.DOUBLE_BUF(DOUBLE_BUF)) i_buf (
      .clk(clk), .rst(rst), .setup_rcvd(setup_rcvd),
      .clr_out_acc(clr_out_acc), .cpu_buf(cpu_buf)
   );

   generate
      for (genvar g = 0; g < N_GATED; g++) begin : g_go
         always_ff @(posedge clk) begin
            if (rst) go_q[g] <= 1'b0;
            else     go_q[g] <= gated && !blocked && (gated_idx(op) == g);
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) rej_q <= 1'b0;
      else     rej_q <= gated && blocked;
   end

   assign val_out_go = go_q[0];
   assign val_in_go  = go_q[1];
   assign clr_out_go = go_q[2];
   assign clr_in_go  = go_q[3];
   assign cmd_rej    = rej_q;

   always_comb begin
      stat_img           = '0;
      stat_img[BIT_OVW]  = ovw;
      stat_img[BIT_PRES] = present;
      stat_img[BIT_BUF]  = cpu_buf;
   end

   a_r4_refuse: assert property (@(posedge clk) disable iff (rst)
      (gated && blocked) |=> (cmd_rej && go_q == '0));
   a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
      $onehot0({go_q, rej_q}));
   a_r12_other_quiet: assert property (@(posedge clk) disable iff (rst)
      (op == OP_NONE) |=> (go_q == '0 && !rej_q));

endmodule

// File: tb/test_ctl_setup_lockout.sv
module test_ctl_setup_lockout;

   localparam logic [7:0] C_ACK = 8'hF4, C_VO = 8'hFA, C_VI = 8'hFB,
                          C_CO = 8'hF2, C_CI = 8'hF3;

   logic       clk = 1'b0, rst = 1'b1;
   logic       setup_rcvd = 0, setup_wr_done = 0, stall_evt = 0;
   logic [7:0] cmd_code = 8'h00;
   logic       cmd_stb = 0, stat_rd = 0;
   logic [7:0] stat_img;
   logic       val_out_go, val_in_go, clr_out_go, clr_in_go, cmd_rej;

   int n_cmp = 0, n_bad = 0;
   bit done = 0;

   // model state
   bit m_lock, m_win, m_ovw, m_pres, m_buf;
   bit m_vo, m_vi, m_co, m_ci, m_rej;

   always #2 clk = ~clk;

   ctl_setup_lockout i_ctl_setup_lockout (
      .clk(clk), .rst(rst), .setup_rcvd(setup_rcvd),
      .setup_wr_done(setup_wr_done), .stall_evt(stall_evt),
      .cmd_code(cmd_code), .cmd_stb(cmd_stb), .stat_rd(stat_rd),
      .stat_img(stat_img), .val_out_go(val_out_go), .val_in_go(val_in_go),
      .clr_out_go(clr_out_go), .clr_in_go(clr_in_go), .cmd_rej(cmd_rej)
   );

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic compare();
      chk("R6 R7 R8 R9 R10 R11 stat_img", stat_img,
          {4'b0, m_ovw, m_pres, m_buf, 1'b0});
      chk("R2 R3 R4 R5 R12 pulses",
          {3'b0, val_out_go, val_in_go, clr_out_go, clr_in_go, cmd_rej},
          {3'b0, m_vo, m_vi, m_co, m_ci, m_rej});
   endtask

   task automatic model_reset();
      {m_lock, m_win, m_ovw, m_pres, m_buf} = '0;
      {m_vo, m_vi, m_co, m_ci, m_rej} = '0;
   endtask

   // apply one cycle of inputs at negedge: compare, drive, advance model
   task automatic step(input bit su, input bit st, input bit dn, input bit rd,
                       input bit sb, input logic [7:0] cd);
      bit gated, blk, ack, co_acc;
      compare();
      setup_rcvd = su; stall_evt = st; setup_wr_done = dn;
      stat_rd = rd; cmd_stb = sb; cmd_code = cd;
      gated  = sb && (cd == C_VO || cd == C_VI || cd == C_CO || cd == C_CI);
      blk    = m_lock || su;
      ack    = sb && cd == C_ACK;
      co_acc = sb && cd == C_CO && !blk;
      m_vo  = gated && !blk && cd == C_VO;
      m_vi  = gated && !blk && cd == C_VI;
      m_co  = co_acc;
      m_ci  = gated && !blk && cd == C_CI;
      m_rej = gated && blk;
      if (su && m_win) m_ovw = 1; else if (rd && dn) m_ovw = 0;
      if (su) m_buf = 0; else if (co_acc) m_buf = ~m_buf;
      if (su) m_pres = 1; else if (co_acc) m_pres = 0;
      if (su) m_win = 1; else if (ack || st) m_win = 0;
      if (su) m_lock = 1; else if (ack) m_lock = 0;
      @(negedge clk);
   endtask

   initial begin
      #800000;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      if (!done) $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 reset image", stat_img, 8'h00);
      chk("R1 reset pulses", {3'b0, val_out_go, val_in_go, clr_out_go, clr_in_go, cmd_rej}, 8'h00);
      rst = 0;
      // directed walk
      step(0,0,0,0,1,C_CO);  // R5 accepted clear OUT, R10 toggle
      step(0,0,0,0,1,C_VO);
      step(1,0,0,0,1,C_VI);  // R2 same-cycle refusal
      step(0,0,0,0,1,C_CI);  // R4 refused
      step(1,0,0,0,0,8'h00); // R6 overwrite
      step(0,0,0,1,0,8'h00); // R7 read without done: hold
      step(1,0,1,1,0,8'h00); // R8 read collides with set
      step(0,0,1,1,0,8'h00); // R7 clears
      step(0,1,0,0,0,8'h00); // stall closes window
      step(1,0,0,0,0,8'h00); // no overwrite after stall
      step(1,0,0,0,1,C_ACK); // R3 setup wins over ack
      step(0,0,0,0,1,C_VO);  // still refused
      step(0,0,0,0,1,C_ACK); // R3 release
      step(0,0,0,0,1,C_VO);
      step(0,0,0,0,1,8'h00); // R12
      step(0,0,0,0,1,C_CO);  // R9 present clears
      step(0,0,0,0,1,C_CO);
      // near-exhaustive sweep
      for (int i = 0; i < 20000; i++) begin
         logic [31:0] h;
         logic [7:0]  cd;
         h = (i * 32'h9E3779B1) ^ (i >> 5);
         case (h[10:8])
            3'd0, 3'd5: cd = C_ACK;
            3'd1: cd = C_VO;
            3'd2: cd = C_VI;
            3'd3: cd = C_CO;
            3'd4: cd = C_CI;
            3'd6: cd = 8'h00;
            default: cd = 8'hF5;
         endcase
         step(h[2:0] == 3'd0, h[5:3] == 3'd1, h[12], h[13], h[14] | h[15], cd);
      end
      compare();
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule